// File: doc/BRIEF.md
# Laser transmitter control sequencer

This block sits between the host's control pins and a four-lane laser driver and decides, cycle by cycle, which lanes may emit light. A lane is allowed on only while the host keeps the transmitter enabled, not disabled and out of reset, while the supply is reported good and no eye-safety fault is held. Each host control and fault input passes through a two-flop synchronizer before the control logic sees it. Any gating input going inactive switches every lane off in one cycle.

Lanes never start together. After the gate opens, lane 0 waits a long settle delay. Lanes 1, 2 and 3 then follow one at a time in lane order, each after its own step delay. A supply-good rise adds a further power-up wait in front of this ramp. A detected over-current on any lane, an over-temperature or a calibration-corruption flag is latched. The latch pulls the active-low fault output down and keeps the laser dark until the host clears it. The host clears it either by pulsing the control reset low, or by holding enable low for a minimum time and then raising it. Every delay is a parameter counted in clock cycles.

Top module: `lsr_tx_seq`

## Requirements
- R1: `lane_on_o` bit i drives lane i. Lanes may be on only while `dis_i`=0, `en_i`=1, `rstn_i`=1, the supply is ready and no fault is latched. Every other combination of `dis_i`/`en_i`/`rstn_i` leaves all lanes off.
- R2: When any gating input goes inactive, all lanes that are on turn off together on the 3rd rising edge after the change. This holds even when the turn-on ramp is only partly done, and no further lane comes on.
- R3: After the gate opens (inputs changed, then 2 synchronizer edges), lane 0 turns on `T_FIRST` edges later. Lane 1 follows `T_STEP1` edges after lane 0, and each further lane follows `T_STEP` edges after the one before. The lanes that are on always form a contiguous group from lane 0, and at most one lane turns on per cycle.
- R4: After `pg_i` rises, lane 0 turns on 2+`T_PWR`+`T_FIRST` edges later. `pg_i` falling switches all lanes off on the 3rd edge, and the next rise repeats the full power-up wait.
- R5: Any fault input high (`flt_ocur_i[i]`, `flt_temp_i` or `flt_cal_i`) while `rstn_i` is high drives `fault_n_o` low on the 3rd edge and all lanes off on the 4th edge.
- R6: A latched fault keeps `fault_n_o` low and all lanes off after the fault inputs return low, until one of the clears in R7 or R8 occurs.
- R7: A `rstn_i` low of one cycle or more clears the latch: `fault_n_o` goes high on the 3rd edge after the fall. A fault input still high when `rstn_i` returns high latches again on the 3rd edge after the rise.
- R8: Holding `en_i` low for at least `T_ENLOW` cycles and then raising it clears the latch: `fault_n_o` goes high on the 3rd edge after the rise, and the R3 ramp restarts with lane 0 `T_FIRST` edges after that. A low of `T_ENLOW`-1 cycles leaves the fault latched.
- R9: An active fault input in the cycle of an enable-recovery edge wins, so the fault stays latched. A shutdown that lands in the same cycle as a lane step suppresses the step.
- R10: After the synchronous `rst`, all lanes are off and `fault_n_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dis_i | input | 1 | Transmitter disable, active high |
| en_i | input | 1 | Transmitter enable, active high |
| rstn_i | input | 1 | Control reset and fault clear, active low |
| pg_i | input | 1 | Supply good |
| flt_ocur_i | input | LANES | Per-lane laser over-current detect |
| flt_temp_i | input | 1 | Over-temperature detect |
| flt_cal_i | input | 1 | Calibration data corruption detect |
| lane_on_o | output | LANES | Per-lane laser-on enable |
| fault_n_o | output | 1 | Latched fault status, low on fault |

## Verification
Two pairs of events can fall in the same cycle. The first is an enable-recovery edge that meets a fault input still held high. The second is a shutdown that lands on the exact cycle a lane step is due. The bench provokes the first by keeping an over-current input high across a long enable-low window, and judges it by `fault_n_o` staying low and all lanes staying dark. The second is provoked by timing a disable so that its synchronized value arrives on the lane-1 step edge, and is judged by the lane vector reading zero there instead of two lanes.

// File: rtl/lsr_seq_pkg.sv
package lsr_seq_pkg;

    typedef struct packed {
        logic pg;
        logic rstn;
        logic en;
        logic dis;
        logic cal;
        logic temp;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    typedef enum logic [1:0] {
        SEQ_OFF  = 2'd0,
        SEQ_RAMP = 2'd1,
        SEQ_FULL = 2'd2
    } seq_st_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

endpackage

// File: rtl/lsr_sync.sv
module lsr_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[s] <= '0;
            else     stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/lsr_fault_latch.sv
module lsr_fault_latch #(
    parameter int LANES   = 4,
    parameter int T_ENLOW = 100000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] ocur_s,
    input  logic             temp_s,
    input  logic             cal_s,
    input  logic             rstn_s,
    input  logic             en_s,
    output logic             latched,
    output logic             en_clr
);
    localparam int LW = $clog2(T_ENLOW + 1);

    logic [LW-1:0] low_cnt;
    logic          en_d;
    logic          fault_any;

    assign fault_any = (|ocur_s) | temp_s | cal_s;
    assign en_clr    = en_s & ~en_d & (low_cnt >= LW'(T_ENLOW));

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt <= '0;
            en_d    <= 1'b0;
            latched <= 1'b0;
        end else begin
            en_d <= en_s;
            if (!en_s) begin
                if (low_cnt != LW'(T_ENLOW)) low_cnt <= low_cnt + 1'b1;
            end else begin
                low_cnt <= '0;
            end
            if (!rstn_s) latched <= 1'b0;
            else         latched <= fault_any | (latched & ~en_clr);
        end
    end
endmodule

// File: rtl/lsr_lane_seq.sv
module lsr_lane_seq
    import lsr_seq_pkg::*;
#(
    parameter int LANES   = 4,
    parameter int T_PWR   = 300000,
    parameter int T_FIRST = 1800000,
    parameter int T_STEP1 = 420000,
    parameter int T_STEP  = 460000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pg_s,
    input  logic             gate_ok,
    output logic [LANES-1:0] lane_on
);
    localparam int DMAX = max3(T_FIRST, T_STEP1, T_STEP);
    localparam int CW   = $clog2(DMAX + 1);
    localparam int KW   = $clog2(LANES + 1);
    localparam int PW   = $clog2(T_PWR + 1);

    logic [PW-1:0] pwr_cnt;
    logic          pwr_ready;
    logic          run_ok;
    logic [CW-1:0] cnt;
    logic [CW-1:0] step_len;
    logic [KW-1:0] k;
    seq_st_t       st;

    always_ff @(posedge clk) begin
        if (rst || !pg_s) begin
            pwr_cnt   <= '0;
            pwr_ready <= 1'b0;
        end else if (!pwr_ready) begin
            if (pwr_cnt == PW'(T_PWR - 1)) pwr_ready <= 1'b1;
            else                           pwr_cnt   <= pwr_cnt + 1'b1;
        end
    end

    assign run_ok = gate_ok & pg_s & pwr_ready;

    always_comb begin
        if (k == '0)                step_len = CW'(T_FIRST);
        else if (k == KW'(1))       step_len = CW'(T_STEP1);
        else                        step_len = CW'(T_STEP);
    end

    always_ff @(posedge clk) begin
        if (rst || !run_ok) begin
            st  <= SEQ_OFF;
            k   <= '0;
            cnt <= '0;
        end else if (st != SEQ_FULL) begin
            st <= SEQ_RAMP;
            if (cnt == step_len - 1'b1) begin
                cnt <= '0;
                k   <= k + 1'b1;
                if (k == KW'(LANES - 1)) st <= SEQ_FULL;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_on[i] = (k > KW'(i));
    end
endmodule

// File: rtl/lsr_tx_seq.sv
module lsr_tx_seq
    import lsr_seq_pkg::*;
#(
    parameter int LANES       = 4,
    parameter int SYNC_STAGES = 2,
    parameter int T_PWR       = 300000,
    parameter int T_FIRST     = 1800000,
    parameter int T_STEP1     = 420000,
    parameter int T_STEP      = 460000,
    parameter int T_ENLOW     = 100000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dis_i,
    input  logic             en_i,
    input  logic             rstn_i,
    input  logic             pg_i,
    input  logic [LANES-1:0] flt_ocur_i,
    input  logic             flt_temp_i,
    input  logic             flt_cal_i,
    output logic [LANES-1:0] lane_on_o,
    output logic             fault_n_o
);
    localparam int SW = CTL_W + LANES;

    ctl_t             ctl_raw;
    ctl_t             ctl_s;
    logic [LANES-1:0] ocur_s;
    logic             rstn_s;
    logic             en_clr;
    logic             latched;
    logic             gate_ok;

    always_comb begin
        ctl_raw.pg   = pg_i;
        ctl_raw.rstn = rstn_i;
        ctl_raw.en   = en_i;
        ctl_raw.dis  = dis_i;
        ctl_raw.cal  = flt_cal_i;
        ctl_raw.temp = flt_temp_i;
    end

    lsr_sync #(.W(SW), .STAGES(SYNC_STAGES)) i_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ctl_raw, flt_ocur_i}),
        .q   ({ctl_s, ocur_s})
    );

    assign rstn_s = ctl_s.rstn;

    lsr_fault_latch #(.LANES(LANES), .T_ENLOW(T_ENLOW)) i_flt (
        .clk     (clk),
        .rst     (rst),
        .ocur_s  (ocur_s),
        .temp_s  (ctl_s.temp),
        .cal_s   (ctl_s.cal),
        .rstn_s  (rstn_s),
        .en_s    (ctl_s.en),
        .latched (latched),
        .en_clr  (en_clr)
    );

    assign gate_ok = ~ctl_s.dis & ctl_s.en & rstn_s & ~latched;

    lsr_lane_seq #(
        .LANES(LANES), .T_PWR(T_PWR), .T_FIRST(T_FIRST),
        .T_STEP1(T_STEP1), .T_STEP(T_STEP)
    ) i_seq (
        .clk     (clk),
        .rst     (rst),
        .pg_s    (ctl_s.pg),
        .gate_ok (gate_ok),
        .lane_on (lane_on_o)
    );

    assign fault_n_o = ~latched;
endmodule

// File: rtl/lsr_tx_seq_chk.sv
module lsr_tx_seq_chk #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             dis_i,
    input logic             en_i,
    input logic             rstn_i,
    input logic [LANES-1:0] flt_ocur_i,
    input logic             flt_temp_i,
    input logic             flt_cal_i,
    input logic [LANES-1:0] lane_on_o,
    input logic             fault_n_o,
    input logic             rstn_s,
    input logic             en_clr
);
    logic [1:0] age;

    always_ff @(posedge clk) begin
        if (rst)              age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    AST_GATE_SHUTS_LANES: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3 && ($past(dis_i, 3) || !$past(en_i, 3) || !$past(rstn_i, 3)))
        |-> lane_on_o == '0); // R2

    AST_LANES_CONTIGUOUS: assert property (@(posedge clk) disable iff (rst)
        ((lane_on_o + 1'b1) & lane_on_o) == '0); // R3

    AST_ONE_LANE_PER_STEP: assert property (@(posedge clk) disable iff (rst)
        $countones(lane_on_o & ~$past(lane_on_o)) <= 1); // R3

    AST_FAULT_DETECT: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3 && $past(rstn_i, 3) &&
         ((|$past(flt_ocur_i, 3)) || $past(flt_temp_i, 3) || $past(flt_cal_i, 3)))
        |-> !fault_n_o); // R5

    AST_FAULT_DARKENS: assert property (@(posedge clk) disable iff (rst)
        !fault_n_o |=> lane_on_o == '0); // R5

    AST_FAULT_HELD: assert property (@(posedge clk) disable iff (rst)
        (!fault_n_o && rstn_s && !en_clr) |=> !fault_n_o); // R6
endmodule

bind lsr_tx_seq lsr_tx_seq_chk #(.LANES(LANES)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .dis_i      (dis_i),
    .en_i       (en_i),
    .rstn_i     (rstn_i),
    .flt_ocur_i (flt_ocur_i),
    .flt_temp_i (flt_temp_i),
    .flt_cal_i  (flt_cal_i),
    .lane_on_o  (lane_on_o),
    .fault_n_o  (fault_n_o),
    .rstn_s     (rstn_s),
    .en_clr     (en_clr)
);

// File: tb/test_lsr_tx_seq.sv
module test_lsr_tx_seq;
    localparam int LANES   = 4;
    localparam int T_PWR   = 10;
    localparam int T_FIRST = 6;
    localparam int T_STEP1 = 3;
    localparam int T_STEP  = 4;
    localparam int T_ENLOW = 5;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             dis_i = 1'b0;
    logic             en_i = 1'b0;
    logic             rstn_i = 1'b1;
    logic             pg_i = 1'b0;
    logic [LANES-1:0] flt_ocur_i = '0;
    logic             flt_temp_i = 1'b0;
    logic             flt_cal_i = 1'b0;
    logic [LANES-1:0] lane_on_o;
    logic             fault_n_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    lsr_tx_seq #(
        .LANES(LANES), .SYNC_STAGES(2), .T_PWR(T_PWR), .T_FIRST(T_FIRST),
        .T_STEP1(T_STEP1), .T_STEP(T_STEP), .T_ENLOW(T_ENLOW)
    ) i_lsr_tx_seq (
        .clk(clk), .rst(rst), .dis_i(dis_i), .en_i(en_i), .rstn_i(rstn_i),
        .pg_i(pg_i), .flt_ocur_i(flt_ocur_i), .flt_temp_i(flt_temp_i),
        .flt_cal_i(flt_cal_i), .lane_on_o(lane_on_o), .fault_n_o(fault_n_o)
    );

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // ramp expected from now: lane0 after base edges, then step delays (R3)
    task automatic ramp_check(input int base, input string req);
        wait_n(base - 1);         chk({req, " R3 before lane0"}, 32'(lane_on_o), 0);
        wait_n(1);                chk({req, " R3 lane0"}, 32'(lane_on_o), 1);
        wait_n(T_STEP1 - 1);      chk({req, " R3 before lane1"}, 32'(lane_on_o), 1);
        wait_n(1);                chk({req, " R3 lane1"}, 32'(lane_on_o), 3);
        wait_n(T_STEP - 1);       chk({req, " R3 before lane2"}, 32'(lane_on_o), 3);
        wait_n(1);                chk({req, " R3 lane2"}, 32'(lane_on_o), 7);
        wait_n(T_STEP);           chk({req, " R3 lane3"}, 32'(lane_on_o), 15);
    endtask

    task automatic set_fault(input int src, input logic v);
        if (src < LANES)      flt_ocur_i[src] = v;
        else if (src == 4)    flt_temp_i = v;
        else                  flt_cal_i = v;
    endtask

    initial begin
        wait_n(4);
        rst = 1'b0;
        wait_n(1);
        chk("R10 lanes after reset", 32'(lane_on_o), 0);
        chk("R10 fault_n after reset", 32'(fault_n_o), 1);

        // R4 power-up then R3 ramp
        pg_i = 1'b1; en_i = 1'b1;
        ramp_check(2 + T_PWR + T_FIRST, "R4 power-up");

        // R1 sweep over dis/en/rstn, R2 shutdown latency
        for (int c = 0; c < 8; c++) begin
            if (c == 3'b011) continue;
            dis_i = c[2]; en_i = c[1]; rstn_i = c[0];
            wait_n(2); chk("R2 lanes held 2 edges", 32'(lane_on_o), 15);
            wait_n(1); chk("R1 gated off", 32'(lane_on_o), 0);
            wait_n(3); chk("R1 stays off", 32'(lane_on_o), 0);
            dis_i = 1'b0; en_i = 1'b1; rstn_i = 1'b1;
            ramp_check(2 + T_FIRST, "R1 restore");
        end

        // R4 supply drop and repeat wait
        pg_i = 1'b0;
        wait_n(2); chk("R4 pg drop held", 32'(lane_on_o), 15);
        wait_n(1); chk("R4 pg drop off", 32'(lane_on_o), 0);
        pg_i = 1'b1;
        ramp_check(2 + T_PWR + T_FIRST, "R4 repower");

        // R2 abort mid-ramp with two lanes on
        dis_i = 1'b1; wait_n(3);
        dis_i = 1'b0;
        wait_n(2 + T_FIRST + T_STEP1); chk("R2 two lanes", 32'(lane_on_o), 3);
        dis_i = 1'b1;
        wait_n(2); chk("R2 abort held", 32'(lane_on_o), 3);
        wait_n(1); chk("R2 abort all off", 32'(lane_on_o), 0);
        wait_n(T_STEP); chk("R2 no further lane", 32'(lane_on_o), 0);
        dis_i = 1'b0;
        ramp_check(2 + T_FIRST, "R2 restart");

        // R9 shutdown on the lane1 step edge
        dis_i = 1'b1; wait_n(3);
        dis_i = 1'b0;
        wait_n(2 + T_FIRST + T_STEP1 - 3); chk("R9 lane0 on", 32'(lane_on_o), 1);
        dis_i = 1'b1;
        wait_n(2); chk("R9 before step", 32'(lane_on_o), 1);
        wait_n(1); chk("R9 step suppressed", 32'(lane_on_o), 0);
        dis_i = 1'b0;
        ramp_check(2 + T_FIRST, "R9 restart");

        // R5/R6/R7 per fault source
        for (int src = 0; src < 6; src++) begin
            set_fault(src, 1'b1);
            wait_n(2); chk("R5 fault_n before", 32'(fault_n_o), 1);
            wait_n(1); chk("R5 fault_n low", 32'(fault_n_o), 0);
            chk("R5 lanes one edge later", 32'(lane_on_o), 15);
            wait_n(1); chk("R5 lanes off", 32'(lane_on_o), 0);
            set_fault(src, 1'b0);
            wait_n(6);
            chk("R6 fault held", 32'(fault_n_o), 0);
            chk("R6 lanes held off", 32'(lane_on_o), 0);
            rstn_i = 1'b0; wait_n(1); rstn_i = 1'b1;
            wait_n(2); chk("R7 reset clears", 32'(fault_n_o), 1);
            ramp_check(T_FIRST, "R7 ramp after clear");
        end

        // R7 re-latch with fault still active
        flt_temp_i = 1'b1; wait_n(4);
        chk("R5 temp latched", 32'(fault_n_o), 0);
        rstn_i = 1'b0; wait_n(3);
        chk("R7 cleared while reset low", 32'(fault_n_o), 1);
        rstn_i = 1'b1;
        wait_n(2); chk("R7 before relatch", 32'(fault_n_o), 1);
        wait_n(1); chk("R7 relatched", 32'(fault_n_o), 0);
        flt_temp_i = 1'b0;
        rstn_i = 1'b0; wait_n(1); rstn_i = 1'b1;
        ramp_check(2 + T_FIRST, "R7 second clear");

        // R8 enable recovery, short then long
        flt_cal_i = 1'b1; wait_n(1); flt_cal_i = 1'b0;
        wait_n(4);
        chk("R5 cal pulse latched", 32'(fault_n_o), 0);
        en_i = 1'b0; wait_n(T_ENLOW - 1); en_i = 1'b1;
        wait_n(3); chk("R8 short low keeps fault", 32'(fault_n_o), 0);
        wait_n(T_FIRST + 3); chk("R8 short low lanes off", 32'(lane_on_o), 0);
        en_i = 1'b0; wait_n(T_ENLOW); en_i = 1'b1;
        wait_n(2); chk("R8 before release", 32'(fault_n_o), 0);
        wait_n(1); chk("R8 released", 32'(fault_n_o), 1);
        ramp_check(T_FIRST, "R8 ramp");

        // R9 enable recovery with fault still active
        flt_ocur_i[2] = 1'b1; wait_n(4);
        en_i = 1'b0; wait_n(T_ENLOW + 2); en_i = 1'b1;
        wait_n(3); chk("R9 fault wins edge", 32'(fault_n_o), 0);
        wait_n(4); chk("R9 fault still held", 32'(fault_n_o), 0);
        chk("R9 lanes dark", 32'(lane_on_o), 0);
        flt_ocur_i[2] = 1'b0; wait_n(2);
        en_i = 1'b0; wait_n(T_ENLOW); en_i = 1'b1;
        wait_n(3); chk("R8 later release", 32'(fault_n_o), 1);
        ramp_check(T_FIRST, "R8 final ramp");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule